// File: doc/BRIEF.md
# Character LCD Write Sequencer

This block drives a character display over an 8-bit parallel data bus. It uses a register-select line and an enable strobe. After reset is released it runs a fixed start-up script of four command writes: function set, display on, entry mode, then clear. Once the script is done it raises a ready flag and accepts characters, one at a time, from an upstream source.

Each character arrives over a four-phase request/acknowledge handshake. The block writes it to the display as data. Every write, whether command or character, goes through the same timed bus cycle. That cycle has four parts: a setup interval with the bus driven and the strobe low, a strobe pulse, a hold interval with the bus unchanged, and a recovery gap. Each part lasts a number of clock cycles set by a parameter.

Top module: `charlcd_seq`

## Requirements
- R1: While rst_n is low, lcd_en, in_ack, ready, lcd_rs and lcd_db are all 0. No strobe occurs before reset is released.
- R2: After reset, exactly four command writes occur with lcd_rs = 0, in this order of lcd_db values: 8'h33 (function set), 8'h0C (display on), 8'h06 (entry mode), 8'h01 (clear).
- R3: ready rises only after the fourth start-up write has fully completed, gap included. It then stays high until reset.
- R4: lcd_rs and lcd_db hold their value for at least SETUP_CYC clock cycles before lcd_en rises.
- R5: lcd_en stays high for exactly EN_CYC cycles per write. lcd_rs and lcd_db do not change while it is high.
- R6: After lcd_en falls, lcd_rs and lcd_db stay unchanged for at least HOLD_CYC + GAP_CYC cycles. The next rise of lcd_en comes no sooner than HOLD_CYC + GAP_CYC + SETUP_CYC cycles after the fall.
- R7: Each accepted character is written with lcd_rs = 1 and lcd_db equal to in_data. A request made while ready is low is not acknowledged: in_ack stays 0 until ready is high.
- R8: When ready is high and no write is running, in_ack rises on the clock edge after in_req is first seen high. in_ack falls only after in_req has gone low and the character's write has completed.
- R9: in_data is captured at the edge that raises in_ack. Later changes to in_data do not alter the byte that is written.
- R10: One handshake produces exactly one write, however long in_req is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Upstream character request |
| in_data | input | 8 | Character code from upstream |
| in_ack | output | 1 | Handshake acknowledge |
| ready | output | 1 | Start-up script finished, characters accepted |
| lcd_db | output | 8 | Display data bus |
| lcd_rs | output | 1 | Register select: 0 command, 1 character |
| lcd_en | output | 1 | Display enable strobe |

## Verification
Two events can fall in the same cycle: a character request that is already pending, and the completion of the last start-up write. The bench provokes this by raising in_req right after reset and holding it through the whole script. It then judges the outcome in three ways. in_ack must stay low while ready is low, and must rise exactly one cycle after ready rises. The scoreboard must see the character only after the four commands, with all bus timing intact.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_GAP
   } bus_phase_t;

   typedef enum logic [1:0] {
      HS_IDLE,
      HS_WRITE,
      HS_FIN
   } hs_state_t;

   localparam int unsigned SCRIPT_LEN = 4;

   localparam logic [7:0] CMD_FUNC_SET  = 8'h33;
   localparam logic [7:0] CMD_DISP_ON   = 8'h0C;
   localparam logic [7:0] CMD_ENTRY     = 8'h06;
   localparam logic [7:0] CMD_CLEAR     = 8'h01;

endpackage

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
   import lcd_seq_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       cmd
);

   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("lcd_init_rom: IDX_W too narrow for the script");
      end
   endgenerate

   always_comb begin
      unique case (idx)
         IDX_W'(0): cmd = CMD_FUNC_SET;
         IDX_W'(1): cmd = CMD_DISP_ON;
         IDX_W'(2): cmd = CMD_ENTRY;
         IDX_W'(3): cmd = CMD_CLEAR;
         default:   cmd = 8'h00;
      endcase
   end

endmodule

// File: rtl/lcd_strobe_engine.sv
module lcd_strobe_engine
   import lcd_seq_pkg::*;
#(
   parameter int unsigned DB_W      = 8,
   parameter int unsigned SETUP_CYC = 2,
   parameter int unsigned EN_CYC    = 3,
   parameter int unsigned HOLD_CYC  = 2,
   parameter int unsigned GAP_CYC   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            start_rs,
   input  logic [DB_W-1:0] start_db,
   output logic            idle,
   output logic            done,
   output logic            lcd_en,
   output logic            lcd_rs,
   output logic [DB_W-1:0] lcd_db
);

   localparam int unsigned MAX_AB  = (SETUP_CYC > EN_CYC) ? SETUP_CYC : EN_CYC;
   localparam int unsigned MAX_CD  = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
   localparam int unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("lcd_strobe_engine: SETUP_CYC must be at least 1");
      end
      if (EN_CYC < 1) begin : g_bad_en
         $error("lcd_strobe_engine: EN_CYC must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("lcd_strobe_engine: HOLD_CYC must be at least 1");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("lcd_strobe_engine: GAP_CYC must be at least 1");
      end
   endgenerate

   bus_phase_t       phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last;

   assign last = (cnt_q == '0);

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               phase_d = PH_SETUP;
               cnt_d   = CNT_W'(SETUP_CYC - 1);
            end
         end
         PH_SETUP: begin
            if (last) begin
               phase_d = PH_STROBE;
               cnt_d   = CNT_W'(EN_CYC - 1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_STROBE: begin
            if (last) begin
               phase_d = PH_HOLD;
               cnt_d   = CNT_W'(HOLD_CYC - 1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_HOLD: begin
            if (last) begin
               phase_d = PH_GAP;
               cnt_d   = CNT_W'(GAP_CYC - 1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_GAP: begin
            if (last) begin
               phase_d = PH_IDLE;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         lcd_en  <= 1'b0;
         lcd_rs  <= 1'b0;
         lcd_db  <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         lcd_en  <= (phase_d == PH_STROBE);
         if (phase_q == PH_IDLE && start) begin
            lcd_rs <= start_rs;
            lcd_db <= start_db;
         end
      end
   end

   assign idle = (phase_q == PH_IDLE);
   assign done = (phase_q == PH_GAP) && last;

   assert_setup_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_en) |-> $stable({lcd_rs, lcd_db}));

   assert_strobe_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_en && $past(lcd_en)) |-> $stable({lcd_rs, lcd_db}));

   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) |-> $stable({lcd_rs, lcd_db}));

   assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !idle) |=> $stable({lcd_rs, lcd_db}));

endmodule

// File: rtl/lcd_req_ack.sv
module lcd_req_ack
   import lcd_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic ready,
   input  logic eng_idle,
   input  logic eng_done,
   output logic accept,
   output logic ack
);

   hs_state_t hs_q, hs_d;

   assign accept = (hs_q == HS_IDLE) && ready && req && eng_idle;

   always_comb begin
      hs_d = hs_q;
      unique case (hs_q)
         HS_IDLE:  if (accept)   hs_d = HS_WRITE;
         HS_WRITE: if (eng_done) hs_d = HS_FIN;
         HS_FIN:   if (!req)     hs_d = HS_IDLE;
         default:                hs_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q <= HS_IDLE;
         ack  <= 1'b0;
      end else begin
         hs_q <= hs_d;
         ack  <= (hs_d != HS_IDLE);
      end
   end

   assert_ack_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(ready));

   assert_ack_rise_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(req));

   assert_ack_fall_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> !$past(req));

endmodule

// File: rtl/charlcd_seq.sv
module charlcd_seq
   import lcd_seq_pkg::*;
#(
   parameter int unsigned SETUP_CYC = 2,
   parameter int unsigned EN_CYC    = 3,
   parameter int unsigned HOLD_CYC  = 2,
   parameter int unsigned GAP_CYC   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_req,
   input  logic [7:0] in_data,
   output logic       in_ack,
   output logic       ready,
   output logic [7:0] lcd_db,
   output logic       lcd_rs,
   output logic       lcd_en
);

   localparam int unsigned DB_W  = 8;
   localparam int unsigned IDX_W = $clog2(SCRIPT_LEN + 1);

   logic [IDX_W-1:0] step_q;
   logic             run_q;
   logic [7:0]       rom_cmd;
   logic             eng_idle, eng_done, eng_start;
   logic             init_start, accept;
   logic [DB_W-1:0]  eng_db;

   assign ready = (step_q == IDX_W'(SCRIPT_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         run_q  <= 1'b0;
      end else begin
         run_q <= 1'b1;
         if (eng_done && !ready) begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   lcd_init_rom #(
      .IDX_W (IDX_W)
   ) u_rom (
      .idx (step_q),
      .cmd (rom_cmd)
   );

   lcd_req_ack u_hs (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (in_req),
      .ready    (ready),
      .eng_idle (eng_idle),
      .eng_done (eng_done),
      .accept   (accept),
      .ack      (in_ack)
   );

   assign init_start = run_q && !ready && eng_idle;
   assign eng_start  = init_start || accept;
   assign eng_db     = ready ? in_data : rom_cmd;

   lcd_strobe_engine #(
      .DB_W      (DB_W),
      .SETUP_CYC (SETUP_CYC),
      .EN_CYC    (EN_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .GAP_CYC   (GAP_CYC)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eng_start),
      .start_rs (ready),
      .start_db (eng_db),
      .idle     (eng_idle),
      .done     (eng_done),
      .lcd_en   (lcd_en),
      .lcd_rs   (lcd_rs),
      .lcd_db   (lcd_db)
   );

   always_comb begin
      if (!rst_n) begin
         assert_quiet_in_reset_R1: assert (!lcd_en && !in_ack);
      end
   end

   assert_cmd_rs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_en && !ready) |-> !lcd_rs);

   assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   assert_char_rs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_en && ready) |-> lcd_rs);

endmodule

// File: tb/tb_charlcd_seq.sv
module tb_charlcd_seq;

   localparam int T_SETUP = 2;
   localparam int T_EN    = 3;
   localparam int T_HOLD  = 2;
   localparam int T_GAP   = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_req;
   logic [7:0] in_data;
   logic       in_ack, ready, lcd_rs, lcd_en;
   logic [7:0] lcd_db;

   always #5 clk = ~clk;

   charlcd_seq #(
      .SETUP_CYC (T_SETUP),
      .EN_CYC    (T_EN),
      .HOLD_CYC  (T_HOLD),
      .GAP_CYC   (T_GAP)
   ) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_req  (in_req),
      .in_data (in_data),
      .in_ack  (in_ack),
      .ready   (ready),
      .lcd_db  (lcd_db),
      .lcd_rs  (lcd_rs),
      .lcd_en  (lcd_en)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int rises  = 0;
   int falls  = 0;
   logic [8:0] exp_q[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor and scoreboard
   logic [8:0] bus, prev_bus;
   logic       prev_en;
   int         stable_cnt, en_cnt, low_cnt;
   bit         seen_fall;

   initial begin
      prev_bus = '0; prev_en = 1'b0; stable_cnt = 0; en_cnt = 0; low_cnt = 0; seen_fall = 0;
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         bus = {lcd_rs, lcd_db};
         if (bus != prev_bus) stable_cnt = 1; else stable_cnt++;
         if (lcd_en && !prev_en) begin
            rises++;
            chk(stable_cnt - 1 >= T_SETUP, "R4 setup cycles", stable_cnt - 1, T_SETUP);
            if (seen_fall)
               chk(low_cnt >= T_HOLD + T_GAP + T_SETUP, "R6 strobe spacing",
                   low_cnt, T_HOLD + T_GAP + T_SETUP);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10 unexpected write", int'(bus), 0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk(bus == e, "R2/R7/R9 written word", int'(bus), int'(e));
            end
            en_cnt = 1;
         end else if (lcd_en && prev_en) begin
            en_cnt++;
            chk(bus == prev_bus, "R5 bus during strobe", int'(bus), int'(prev_bus));
         end else if (!lcd_en && prev_en) begin
            falls++;
            chk(en_cnt == T_EN, "R5 strobe width", en_cnt, T_EN);
            chk(bus == prev_bus, "R6 bus at fall", int'(bus), int'(prev_bus));
            low_cnt = 1;
            seen_fall = 1;
         end else begin
            if (seen_fall && bus != prev_bus)
               chk(low_cnt >= T_HOLD + T_GAP, "R6 hold after fall", low_cnt, T_HOLD + T_GAP);
            low_cnt++;
         end
         prev_bus = bus;
         prev_en  = lcd_en;
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   // one full handshake; hold = cycles req stays high after ack
   task automatic send(input logic [7:0] d, input int hold);
      int lat;
      int base;
      while (in_ack) @(negedge clk);
      base = falls;
      in_data = d;
      in_req  = 1'b1;
      exp_q.push_back({1'b1, d});
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!in_ack && lat < 100);
      chk(lat == 1, "R8 ack latency", lat, 1);
      in_data = ~d;
      repeat (hold) @(negedge clk);
      in_req = 1'b0;
      lat = 0;
      while (in_ack && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      chk(falls == base + 1, "R8/R10 write done before ack low", falls - base, 1);
      chk(!lcd_en, "R8 strobe over at ack low", int'(lcd_en), 0);
   endtask

   initial begin
      int guard;
      rst_n   = 1'b0;
      in_req  = 1'b0;
      in_data = 8'h00;
      repeat (4) begin
         @(negedge clk);
         chk(!lcd_en && !in_ack && !ready && !lcd_rs && lcd_db == 8'h00,
             "R1 reset outputs", int'({lcd_en, in_ack, ready, lcd_rs, lcd_db}), 0);
      end
      exp_q.push_back({1'b0, 8'h33});
      exp_q.push_back({1'b0, 8'h0C});
      exp_q.push_back({1'b0, 8'h06});
      exp_q.push_back({1'b0, 8'h01});
      rst_n = 1'b1;

      // request pending across the end of the start-up script
      in_data = 8'h41;
      in_req  = 1'b1;
      exp_q.push_back({1'b1, 8'h41});
      guard = 0;
      @(negedge clk);
      while (!ready && guard < 1000) begin
         chk(!in_ack, "R7 no ack before ready", int'(in_ack), 0);
         @(negedge clk);
         guard++;
      end
      chk(ready, "R3 ready reached", int'(ready), 1);
      chk(falls == 4, "R3 ready after four writes", falls, 4);
      chk(!in_ack, "R8 ack not same cycle as ready", int'(in_ack), 0);
      @(negedge clk);
      chk(in_ack, "R8 ack one cycle after ready", int'(in_ack), 1);
      in_data = 8'hBE;
      @(negedge clk);
      in_req = 1'b0;
      guard = 0;
      while (in_ack && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      chk(falls == 5, "R8 early char written once", falls, 5);

      send(8'h00, 0);
      send(8'hFF, 3);
      send(8'h55, 1);
      send(8'h55, 0);
      send(8'h7E, 40);

      repeat (30) @(negedge clk);
      chk(rises == 10, "R10 total writes", rises, 10);
      chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
      chk(ready, "R3 ready still high", int'(ready), 1);
      finish_run();
   end

endmodule